// File: doc/BRIEF.md
# Serial Flash Command Port Arbiter

This block lets four independent client engines share one low-level serial flash command port. The four clients are a read engine, an erase/program engine, an identification/one-time-programmable engine and a control-register engine. A client raises its request line and waits until the arbiter reports it as owner. From then on, any command word the client presents with its write strobe is forwarded straight to the shared port. A forwarded command carries a 32-bit word, a length code, a direction bit, a quad-lane bit and a hold bit.

The port's busy flag, its valid pulse and its returned data are steered back to the owning client alone. Ownership ends when the owner drops its request while the port is idle. A client can chain several command words into one flash transaction by setting the hold bit on all but the last word. While such a chain is open, ownership cannot be lost, so no other client can insert a command into the middle of the transaction.

Top module: `flash_port_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `owned` is low, `port_wr` is low and every bit of `cl_valid` is low, whatever the clients and the port drive.
- R2: When the port is unowned at a rising clock edge and at least one request is high, the lowest-numbered requesting client is granted at that edge: `owned` is high from the following cycle.
- R3: `owner` identifies the granted client with the codes 0 = read, 1 = erase/program, 2 = identification/OTP and 3 = control-register. Each client's request, strobe and return bits sit at the bit position equal to its code.
- R4: Ownership never passes directly from one client to another. While `owned` is high, `owner` stays constant, even if a lower-numbered client raises its request.
- R5: At a rising edge where the owner's request is low, `port_busy` is low and no hold chain is open, ownership is released and `owned` is low in the following cycle. While `port_busy` is high, ownership is kept.
- R6: A forwarded command with its hold bit set opens a hold chain. The chain closes when the owner forwards a command with the hold bit clear. While the chain is open, ownership is kept even with the owner's request low. After the closing word, release follows one edge later under the conditions of R5.
- R7: While a client owns the port, its strobe drives `port_wr` in the same cycle. Its word, length code (length = (code+1)*8 bits), direction bit (1 = read, 0 = write), quad bit (1 = four data lanes) and hold bit appear unchanged on the port outputs.
- R8: Strobes and command fields from clients that do not own the port never reach the port outputs. A hold bit on such a command does not open a chain.
- R9: `port_valid` and `port_rdata` are steered only to the owner's `cl_valid` bit and `cl_rdata` slice (bits 32*code+31 down to 32*code). Every other client sees valid low and data zero, and all clients do so while the port is unowned.
- R10: The owner's `cl_busy` bit follows `port_busy`. Every other client, and every client while the port is unowned, sees its `cl_busy` bit high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cl_req | input | 4 | Per-client ownership request |
| cl_wr | input | 4 | Per-client command strobe |
| cl_word | input | 128 | Per-client 32-bit command word, client k at bits 32k+31:32k |
| cl_len | input | 8 | Per-client length code, client k at bits 2k+1:2k |
| cl_dir | input | 4 | Per-client direction bit, 1 = read |
| cl_quad | input | 4 | Per-client quad-lane bit |
| cl_hold | input | 4 | Per-client hold bit, keeps the transaction open |
| cl_busy | output | 4 | Per-client view of port busy |
| cl_valid | output | 4 | Per-client view of the port's valid pulse |
| cl_rdata | output | 128 | Per-client view of returned data |
| port_wr | output | 1 | Command strobe to the shared port |
| port_word | output | 32 | Command word to the shared port |
| port_len | output | 2 | Length code to the shared port |
| port_dir | output | 1 | Direction bit to the shared port |
| port_quad | output | 1 | Quad-lane bit to the shared port |
| port_hold | output | 1 | Hold bit to the shared port |
| port_busy | input | 1 | Shared port is shifting a command |
| port_valid | input | 1 | Shared port has returned a data word |
| port_rdata | input | 32 | Data word returned by the shared port |
| owned | output | 1 | Some client holds the port |
| owner | output | 2 | Code of the owning client, meaningful while owned is high |

## Verification
The grant logic is driven with several request patterns: two requests at once, all four at once, a single request, and a lower-numbered request arriving while another client holds the port. Together these separate a correct fixed-priority choice from a round-robin choice or from a choice that preempts the current owner. Strobes are sent with all four clients strobing at once and with only non-owners strobing, with a distinct word from each client. This shows whether the multiplexer selects by owner and whether non-owner traffic leaks to the port. Release is tried with the port busy, with a hold chain open and with neither, to separate the three conditions that keep ownership. Returned data is presented while the port is owned and while it is unowned, to confirm that it is steered to the owner only.

// File: rtl/flash_arb_pkg.sv
`timescale 1ns/1ps
package flash_arb_pkg;

    localparam int N_CLIENTS = 4;
    localparam int OWN_W     = $clog2(N_CLIENTS);
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 2;

    // Client codes; priority falls with increasing code.
    typedef enum logic [OWN_W-1:0] {
        CL_READ   = 2'd0,
        CL_ERASE  = 2'd1,
        CL_IDENT  = 2'd2,
        CL_CTRL   = 2'd3
    } client_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LEN_W-1:0]  len;
        logic              dir;
        logic              quad;
        logic              hold;
    } cmd_t;

    typedef struct packed {
        logic    owned;
        client_e owner;
        logic    hold_pend;
    } arb_state_t;

endpackage

// File: rtl/arb_prio_pick.sv
`timescale 1ns/1ps
module arb_prio_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/arb_cmd_mux.sv
`timescale 1ns/1ps
module arb_cmd_mux
    import flash_arb_pkg::*;
#(
    parameter int N = N_CLIENTS,
    parameter int W = OWN_W
) (
    input  logic              en,
    input  logic [W-1:0]      sel,
    input  logic [N-1:0]      wr,
    input  logic [N*WORD_W-1:0] word,
    input  logic [N*LEN_W-1:0]  len,
    input  logic [N-1:0]      dir,
    input  logic [N-1:0]      quad,
    input  logic [N-1:0]      hold,
    output logic              fwd_wr,
    output cmd_t              fwd_cmd
);

    cmd_t cmds [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign cmds[g].word = word[g*WORD_W +: WORD_W];
        assign cmds[g].len  = len[g*LEN_W +: LEN_W];
        assign cmds[g].dir  = dir[g];
        assign cmds[g].quad = quad[g];
        assign cmds[g].hold = hold[g];
    end

    always_comb begin
        fwd_wr  = 1'b0;
        fwd_cmd = '0;
        if (en) begin
            fwd_wr  = wr[sel];
            fwd_cmd = cmds[sel];
        end
    end

endmodule

// File: rtl/arb_return_steer.sv
`timescale 1ns/1ps
module arb_return_steer
    import flash_arb_pkg::*;
#(
    parameter int N = N_CLIENTS,
    parameter int W = OWN_W
) (
    input  logic                owned,
    input  logic [W-1:0]        owner,
    input  logic                port_busy,
    input  logic                port_valid,
    input  logic [WORD_W-1:0]   port_rdata,
    output logic [N-1:0]        cl_busy,
    output logic [N-1:0]        cl_valid,
    output logic [N*WORD_W-1:0] cl_rdata
);

    for (genvar g = 0; g < N; g++) begin : g_client
        logic mine;
        assign mine        = owned && (owner == W'(g));
        assign cl_busy[g]  = !mine || port_busy;
        assign cl_valid[g] = mine && port_valid;
        assign cl_rdata[g*WORD_W +: WORD_W] = mine ? port_rdata : '0;
    end

endmodule

// File: rtl/flash_port_arbiter.sv
`timescale 1ns/1ps
module flash_port_arbiter
    import flash_arb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CLIENTS-1:0]        cl_req,
    input  logic [N_CLIENTS-1:0]        cl_wr,
    input  logic [N_CLIENTS*WORD_W-1:0] cl_word,
    input  logic [N_CLIENTS*LEN_W-1:0]  cl_len,
    input  logic [N_CLIENTS-1:0]        cl_dir,
    input  logic [N_CLIENTS-1:0]        cl_quad,
    input  logic [N_CLIENTS-1:0]        cl_hold,
    output logic [N_CLIENTS-1:0]        cl_busy,
    output logic [N_CLIENTS-1:0]        cl_valid,
    output logic [N_CLIENTS*WORD_W-1:0] cl_rdata,
    output logic                        port_wr,
    output logic [WORD_W-1:0]           port_word,
    output logic [LEN_W-1:0]            port_len,
    output logic                        port_dir,
    output logic                        port_quad,
    output logic                        port_hold,
    input  logic                        port_busy,
    input  logic                        port_valid,
    input  logic [WORD_W-1:0]           port_rdata,
    output logic                        owned,
    output logic [OWN_W-1:0]            owner
);

    arb_state_t st_d, st_q;

    logic             pick_any;
    logic [OWN_W-1:0] pick_idx;
    logic             fwd_wr;
    cmd_t             fwd_cmd;

    arb_prio_pick #(.N(N_CLIENTS), .W(OWN_W)) i_pick (
        .req (cl_req),
        .any (pick_any),
        .idx (pick_idx)
    );

    arb_cmd_mux #(.N(N_CLIENTS), .W(OWN_W)) i_mux (
        .en      (st_q.owned),
        .sel     (st_q.owner),
        .wr      (cl_wr),
        .word    (cl_word),
        .len     (cl_len),
        .dir     (cl_dir),
        .quad    (cl_quad),
        .hold    (cl_hold),
        .fwd_wr  (fwd_wr),
        .fwd_cmd (fwd_cmd)
    );

    arb_return_steer #(.N(N_CLIENTS), .W(OWN_W)) i_steer (
        .owned      (st_q.owned),
        .owner      (st_q.owner),
        .port_busy  (port_busy),
        .port_valid (port_valid),
        .port_rdata (port_rdata),
        .cl_busy    (cl_busy),
        .cl_valid   (cl_valid),
        .cl_rdata   (cl_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.owned) begin
            if (pick_any) begin
                st_d.owned     = 1'b1;
                st_d.owner     = client_e'(pick_idx);
                st_d.hold_pend = 1'b0;
            end
        end else begin
            if (fwd_wr) begin
                st_d.hold_pend = fwd_cmd.hold;
            end
            if (!cl_req[st_q.owner] && !port_busy && !st_q.hold_pend
                && !(fwd_wr && fwd_cmd.hold)) begin
                st_d.owned     = 1'b0;
                st_d.hold_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owned: 1'b0, owner: CL_READ, hold_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign port_wr   = fwd_wr;
    assign port_word = fwd_cmd.word;
    assign port_len  = fwd_cmd.len;
    assign port_dir  = fwd_cmd.dir;
    assign port_quad = fwd_cmd.quad;
    assign port_hold = fwd_cmd.hold;
    assign owned     = st_q.owned;
    assign owner     = st_q.owner;

endmodule

// File: rtl/flash_port_arbiter_chk.sv
`timescale 1ns/1ps
module flash_port_arbiter_chk
    import flash_arb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CLIENTS-1:0] cl_req,
    input logic [N_CLIENTS-1:0] cl_wr,
    input logic [N_CLIENTS-1:0] cl_valid,
    input logic                 port_wr,
    input logic                 port_hold,
    input logic                 port_busy,
    input logic                 port_valid,
    input logic                 owned,
    input logic [OWN_W-1:0]     owner
);

    // R8: a strobe on the port always comes from the owner
    a_r8_fwd_from_owner: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |-> (owned && cl_wr[owner]));

    // R4: the owner code cannot change while ownership persists
    a_r4_owner_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && $past(owned)) |-> (owner == $past(owner)));

    // R2: an unowned port with any request is granted at the next edge
    a_r2_grant_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned && (|cl_req)) |=> owned);

    // R5: a busy port keeps its owner
    a_r5_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && port_busy) |=> owned);

    // R6: a held command keeps its owner for the next cycle
    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_hold) |=> (owned && $stable(owner)));

    // R9: at most one client sees valid, and only when the port reports it
    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cl_valid));

    a_r9_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_valid != '0) |-> (owned && port_valid && cl_valid[owner]));

endmodule

bind flash_port_arbiter flash_port_arbiter_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cl_req     (cl_req),
    .cl_wr      (cl_wr),
    .cl_valid   (cl_valid),
    .port_wr    (port_wr),
    .port_hold  (port_hold),
    .port_busy  (port_busy),
    .port_valid (port_valid),
    .owned      (owned),
    .owner      (owner)
);

// File: tb/test_flash_port_arbiter.sv
`timescale 1ns/1ps
module test_flash_port_arbiter;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   cl_req = '0;
    logic [3:0]   cl_wr = '0;
    logic [127:0] cl_word = '0;
    logic [7:0]   cl_len = '0;
    logic [3:0]   cl_dir = '0;
    logic [3:0]   cl_quad = '0;
    logic [3:0]   cl_hold = '0;
    logic [3:0]   cl_busy;
    logic [3:0]   cl_valid;
    logic [127:0] cl_rdata;
    logic         port_wr;
    logic [31:0]  port_word;
    logic [1:0]   port_len;
    logic         port_dir;
    logic         port_quad;
    logic         port_hold;
    logic         port_busy = 1'b0;
    logic         port_valid = 1'b0;
    logic [31:0]  port_rdata = '0;
    logic         owned;
    logic [1:0]   owner;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_port_arbiter i_flash_port_arbiter (
        .clk(clk), .rst_n(rst_n),
        .cl_req(cl_req), .cl_wr(cl_wr), .cl_word(cl_word), .cl_len(cl_len),
        .cl_dir(cl_dir), .cl_quad(cl_quad), .cl_hold(cl_hold),
        .cl_busy(cl_busy), .cl_valid(cl_valid), .cl_rdata(cl_rdata),
        .port_wr(port_wr), .port_word(port_word), .port_len(port_len),
        .port_dir(port_dir), .port_quad(port_quad), .port_hold(port_hold),
        .port_busy(port_busy), .port_valid(port_valid), .port_rdata(port_rdata),
        .owned(owned), .owner(owner)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cmd(input int k, input logic [31:0] w, input logic [1:0] l,
                           input logic d, input logic q, input logic h);
        cl_word[k*32 +: 32] = w;
        cl_len[k*2 +: 2]    = l;
        cl_dir[k]           = d;
        cl_quad[k]          = q;
        cl_hold[k]          = h;
    endtask

    task automatic go_idle();
        cl_req = '0; cl_wr = '0; cl_hold = '0;
        port_busy = 1'b0; port_valid = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        cl_req = 4'hF; cl_wr = 4'hF; port_valid = 1'b1;
        cyc(2);
        chk("R1 owned in reset", owned, 0);
        chk("R1 port_wr in reset", port_wr, 0);
        chk("R1 cl_valid in reset", cl_valid, 0);
        cl_req = '0; cl_wr = '0; port_valid = 1'b0;
        rst_n = 1'b1;
        #1;
        chk("R1 owned after reset", owned, 0);
        cyc(1);
    endtask

    task automatic t_priority();
        cl_req = 4'b1100; cyc(1);
        chk("R2 grant of two", owned, 1);
        chk("R3 code ident", owner, 2);
        cl_req = 4'b1000; cyc(1);
        chk("R5 release when request drops", owned, 0);
        cyc(1);
        chk("R3 code ctrl", owner, 3);
        chk("R2 grant of single", owned, 1);
        cl_req = '0; cyc(1);
        cl_req = 4'b1111; cyc(1);
        chk("R3 code read of four", owner, 0);
        cl_req = 4'b1110; cyc(2);
        chk("R3 code erase", owner, 1);
        chk("R2 next grant", owned, 1);
        go_idle();
    endtask

    task automatic t_no_preempt();
        cl_req = 4'b1000; cyc(1);
        cl_req = 4'b1001; cyc(3);
        chk("R4 no preempt owned", owned, 1);
        chk("R4 no preempt owner", owner, 3);
        cl_req = 4'b0001; cyc(2);
        chk("R4 handover via unowned", owner, 0);
        go_idle();
    endtask

    task automatic t_busy();
        cl_req = 4'b0010; cyc(1);
        port_busy = 1'b1; cl_req = '0; cyc(4);
        chk("R5 busy keeps owner", owned, 1);
        port_busy = 1'b0; cyc(1);
        chk("R5 release when idle", owned, 0);
        go_idle();
    endtask

    task automatic t_forward();
        set_cmd(0, 32'h1111_0000, 2'd3, 1'b1, 1'b1, 1'b1);
        set_cmd(1, 32'h2222_0001, 2'd1, 1'b0, 1'b1, 1'b0);
        set_cmd(2, 32'h3333_0002, 2'd2, 1'b1, 1'b0, 1'b0);
        set_cmd(3, 32'h4444_0003, 2'd0, 1'b0, 1'b0, 1'b1);
        cl_req = 4'b0100; cyc(1);
        cl_wr = 4'b1111; #1;
        chk("R7 strobe forwarded", port_wr, 1);
        chk("R7 word of owner", port_word, 32'h3333_0002);
        chk("R7 len of owner", port_len, 2);
        chk("R7 dir of owner", port_dir, 1);
        chk("R7 quad of owner", port_quad, 0);
        chk("R7 hold of owner", port_hold, 0);
        cyc(1);
        cl_wr = 4'b1011; #1;
        chk("R8 non-owner strobes ignored", port_wr, 0);
        cyc(1);
        cl_wr = '0; cl_req = '0; cyc(1);
        chk("R8 foreign hold opens no chain", owned, 0);
        go_idle();
    endtask

    task automatic t_hold();
        cl_req = 4'b0010; cyc(1);
        set_cmd(1, 32'hCAFE_0101, 2'd3, 1'b0, 1'b0, 1'b1);
        cl_wr = 4'b0010; cyc(1);
        cl_wr = '0; cl_req = '0; cyc(3);
        chk("R6 chain keeps owned", owned, 1);
        chk("R6 chain keeps owner", owner, 1);
        set_cmd(1, 32'hCAFE_0202, 2'd0, 1'b1, 1'b0, 1'b0);
        cl_wr = 4'b0010; cyc(1);
        cl_wr = '0; cyc(1);
        chk("R6 release after closing word", owned, 0);
        go_idle();
    endtask

    task automatic t_return();
        cl_req = 4'b0100; cyc(1);
        port_valid = 1'b1; port_rdata = 32'hA5C3_0F1E; #1;
        chk("R9 valid to owner", cl_valid, 4'b0100);
        chk("R9 data to owner", cl_rdata, {32'h0, 32'hA5C3_0F1E, 64'h0});
        port_busy = 1'b1; #1;
        chk("R10 busy seen by all", cl_busy, 4'b1111);
        port_busy = 1'b0; #1;
        chk("R10 idle seen by owner", cl_busy, 4'b1011);
        port_valid = 1'b0; cl_req = '0; cyc(1);
        port_valid = 1'b1; #1;
        chk("R9 no valid unowned", cl_valid, 0);
        chk("R9 no data unowned", cl_rdata, 0);
        chk("R10 busy high unowned", cl_busy, 4'b1111);
        go_idle();
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_priority();
        t_no_preempt();
        t_busy();
        t_forward();
        t_hold();
        t_return();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule